// File: doc/BRIEF.md
# DMA Normal-Mode Channel Sequencer

This block is one DMA channel that runs in normal transfer mode. Each accepted transfer request moves exactly one data unit of the programmed access size (byte, halfword or word). A 32-bit byte count sets the total transfer length, so up to 4 Gbytes can be moved. The channel masters a simple bus port. In dual-address mode a transfer is a read bus cycle at the source address, followed by a write bus cycle that carries the same data to the destination. In single-address mode a transfer is one read bus cycle at the source address. The external device takes the data under the acknowledge strobe.

Software loads the configuration inputs and pulses `start`. The channel latches the configuration and enables itself. It then serves requests until the count reaches zero. At that point it drops its enable and raises `done`. A request comes from the level-sensitive `ext_req` pin, or, in dual-address mode with `cfg_auto` set, from the channel itself. `xfer_ack` marks every bus cycle of every transfer. `xfer_end` marks only the bus cycles of the final transfer.

The bus port follows valid/ready rules. While `bus_valid` is high and `bus_ready` is low, the channel holds `bus_valid`, `bus_we`, `bus_addr`, `bus_size` and `bus_wdata` unchanged. A cycle completes on the clock edge where both are high. Read data is taken right-justified from `bus_rdata` on that edge. Write data is presented right-justified on `bus_wdata`. The configuration inputs matter only in the cycle where `start` is accepted.

Top module: `dma_norm_chan`

## Requirements
- R1: A `start` pulse while the channel is disabled, with a nonzero count and a legal size code, latches the configuration, raises `chan_en`, and clears `done` and `cfg_err`. A `start` while `chan_en` is high is ignored.
- R2: A `start` with `cfg_count` of zero, or with size code 3, raises `cfg_err`, leaves `chan_en` low and issues no bus cycle.
- R3: Size codes are 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes. Each transfer moves one unit and takes that many bytes off the count. The count saturates at zero, so the number of transfers is the count divided by the unit size, rounded up.
- R4: In dual-address mode (`cfg_single`=0), each transfer is a read cycle (`bus_we`=0) at the source address. This is followed by a write cycle (`bus_we`=1) at the destination address, carrying the data just read.
- R5: In single-address mode (`cfg_single`=1), each transfer is one read cycle at the source address, and no write cycle is issued.
- R6: Single-address mode is started by the `ext_req` level. Dual-address mode runs on its own when `cfg_auto`=1, and on `ext_req` when `cfg_auto`=0. `ext_req` is sampled only between transfers. A request held high past the final transfer starts no further cycle.
- R7: After each transfer, the source address and the destination address each advance by the unit size if their increment bit is 1, and stay fixed if it is 0.
- R8: `xfer_ack` is high for the full length of every bus cycle of every transfer. `xfer_end` is high only during the bus cycles of the final transfer.
- R9: On the clock edge that completes the final transfer, `chan_en` falls and `done` rises. Both are visible in the next cycle.
- R10: While `bus_valid` is high and `bus_ready` is low, `bus_valid`, `bus_we`, `bus_addr`, `bus_size` and `bus_wdata` stay stable.
- R11: `cfg_blk_size` has no effect in normal mode. Runs that differ only in this input produce identical bus traffic and memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse to load the configuration and enable the channel |
| cfg_src_addr | input | AW | Source start address |
| cfg_dst_addr | input | AW | Destination start address |
| cfg_count | input | CW | Total bytes to move |
| cfg_size | input | 2 | Access size code (0 = byte, 1 = half, 2 = word) |
| cfg_src_inc | input | 1 | 1: source address advances, 0: source address fixed |
| cfg_dst_inc | input | 1 | 1: destination address advances, 0: destination address fixed |
| cfg_single | input | 1 | 1: single-address mode, 0: dual-address mode |
| cfg_auto | input | 1 | Self-trigger in dual-address mode |
| cfg_blk_size | input | BSW | Block size; unused in normal mode |
| ext_req | input | 1 | Level-sensitive external transfer request |
| bus_valid | output | 1 | Bus cycle request |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | output | AW | Bus cycle address |
| bus_size | output | 2 | Bus cycle size code |
| bus_wdata | output | DW | Write data, right-justified |
| bus_ready | input | 1 | Bus cycle completes when high with `bus_valid` |
| bus_rdata | input | DW | Read data, right-justified, valid with `bus_ready` |
| xfer_ack | output | 1 | Acknowledge strobe for every transfer |
| xfer_end | output | 1 | End strobe for the final transfer |
| chan_en | output | 1 | Channel enabled |
| done | output | 1 | Sequence finished |
| cfg_err | output | 1 | Last start was rejected |

## Verification
Completion of the final transfer can fall in the same cycle as a still-asserted request. That request is either the external level held high or the automatic self-trigger. The bench holds `ext_req` high across the whole single-address run and beyond it. It then judges that exactly the counted number of read cycles appear, with `xfer_end` only on the last one, and no cycle after `done` rises. A second collision is a `start` arriving while the channel waits idle for a request. The bench checks that the transfer total still matches the first configuration.

// File: rtl/dmn_pkg.sv
package dmn_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_IDLE = 2'd1,
    ST_RD   = 2'd2,
    ST_WR   = 2'd3
  } dmn_state_e;

  localparam int unsigned STEP_W = 3;

  // Unit size in bytes for a size code; 0 marks an illegal code.
  function automatic logic [STEP_W-1:0] sz_bytes(input logic [1:0] code);
    case (code)
      2'd0:    sz_bytes = 3'd1;
      2'd1:    sz_bytes = 3'd2;
      2'd2:    sz_bytes = 3'd4;
      default: sz_bytes = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/dmn_req_sel.sv
module dmn_req_sel (
  input  logic ext_req,
  input  logic single_mode,
  input  logic auto_mode,
  output logic req
);
  // Self-triggering is only offered in dual-address mode.
  assign req = (auto_mode && !single_mode) ? 1'b1 : ext_req;
endmodule

// File: rtl/dmn_addr_ctr.sv
module dmn_addr_ctr
  import dmn_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [AW-1:0]     load_val,
  input  logic              load_inc,
  input  logic              step_en,
  input  logic [STEP_W-1:0] step,
  output logic [AW-1:0]     addr
);
  logic inc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr  <= '0;
      inc_q <= 1'b0;
    end else if (load) begin
      addr  <= load_val;
      inc_q <= load_inc;
    end else if (step_en && inc_q) begin
      addr  <= addr + AW'(step);
    end
  end
endmodule

// File: rtl/dmn_byte_cnt.sv
module dmn_byte_cnt
  import dmn_pkg::*;
#(
  parameter int unsigned CW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CW-1:0]     load_val,
  input  logic              dec_en,
  input  logic [STEP_W-1:0] step,
  output logic              last
);
  logic [CW-1:0] cnt_q;

  // The current transfer is the last when at most one unit remains.
  assign last = (cnt_q <= CW'(step));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load)   cnt_q <= load_val;
    else if (dec_en) cnt_q <= last ? '0 : cnt_q - CW'(step);
  end
endmodule

// File: rtl/dma_norm_chan.sv
module dma_norm_chan
  import dmn_pkg::*;
#(
  parameter int unsigned AW  = 32,
  parameter int unsigned DW  = 32,
  parameter int unsigned CW  = 32,
  parameter int unsigned BSW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [AW-1:0]  cfg_src_addr,
  input  logic [AW-1:0]  cfg_dst_addr,
  input  logic [CW-1:0]  cfg_count,
  input  logic [1:0]     cfg_size,
  input  logic           cfg_src_inc,
  input  logic           cfg_dst_inc,
  input  logic           cfg_single,
  input  logic           cfg_auto,
  input  logic [BSW-1:0] cfg_blk_size,
  input  logic           ext_req,
  output logic           bus_valid,
  output logic           bus_we,
  output logic [AW-1:0]  bus_addr,
  output logic [1:0]     bus_size,
  output logic [DW-1:0]  bus_wdata,
  input  logic           bus_ready,
  input  logic [DW-1:0]  bus_rdata,
  output logic           xfer_ack,
  output logic           xfer_end,
  output logic           chan_en,
  output logic           done,
  output logic           cfg_err
);
  localparam int unsigned NADDR = 2;   // index 0: source, 1: destination

  dmn_state_e        st_q;
  logic [1:0]        size_q;
  logic              single_q, auto_q;
  logic [DW-1:0]     buf_q;
  logic [STEP_W-1:0] step;
  logic              req, last, cfg_ok, load, xfer_fin;
  logic [AW-1:0]     addr     [NADDR];
  logic [AW-1:0]     addr_ini [NADDR];
  logic              inc_ini  [NADDR];

  // The block size only matters in modes this channel does not run.
  logic unused_blk;
  assign unused_blk = ^cfg_blk_size;

  assign step     = sz_bytes(size_q);
  assign cfg_ok   = (cfg_count != '0) && (sz_bytes(cfg_size) != '0);
  assign load     = (st_q == ST_OFF) && start && cfg_ok;
  assign xfer_fin = bus_ready &&
                    (((st_q == ST_RD) && single_q) || (st_q == ST_WR));

  assign addr_ini[0] = cfg_src_addr;
  assign addr_ini[1] = cfg_dst_addr;
  assign inc_ini[0]  = cfg_src_inc;
  assign inc_ini[1]  = cfg_dst_inc;

  for (genvar g = 0; g < NADDR; g++) begin : g_addr
    dmn_addr_ctr #(.AW(AW)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (addr_ini[g]),
      .load_inc (inc_ini[g]),
      .step_en  (xfer_fin),
      .step     (step),
      .addr     (addr[g])
    );
  end

  dmn_byte_cnt #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (cfg_count),
    .dec_en   (xfer_fin),
    .step     (step),
    .last     (last)
  );

  dmn_req_sel u_req (
    .ext_req     (ext_req),
    .single_mode (single_q),
    .auto_mode   (auto_q),
    .req         (req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_OFF;
      size_q   <= '0;
      single_q <= 1'b0;
      auto_q   <= 1'b0;
      buf_q    <= '0;
      done     <= 1'b0;
      cfg_err  <= 1'b0;
    end else begin
      case (st_q)
        ST_OFF: if (start) begin
          done    <= 1'b0;
          cfg_err <= !cfg_ok;
          if (cfg_ok) begin
            size_q   <= cfg_size;
            single_q <= cfg_single;
            auto_q   <= cfg_auto;
            st_q     <= ST_IDLE;
          end
        end
        ST_IDLE: if (req) st_q <= ST_RD;
        ST_RD: if (bus_ready) begin
          buf_q <= bus_rdata;
          if (!single_q) st_q <= ST_WR;
        end
        ST_WR: ;
        default: st_q <= ST_OFF;
      endcase
      if (xfer_fin) begin
        st_q <= last ? ST_OFF : ST_IDLE;
        if (last) done <= 1'b1;
      end
    end
  end

  assign chan_en   = (st_q != ST_OFF);
  assign xfer_ack  = (st_q == ST_RD) || (st_q == ST_WR);
  assign xfer_end  = xfer_ack && last;
  assign bus_valid = xfer_ack;
  assign bus_we    = (st_q == ST_WR);
  assign bus_addr  = bus_we ? addr[1] : addr[0];
  assign bus_size  = size_q;
  assign bus_wdata = buf_q;
endmodule

// File: rtl/dmn_chan_chk.sv
module dmn_chan_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_valid,
  input logic          bus_ready,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [1:0]    bus_size,
  input logic [DW-1:0] bus_wdata,
  input logic          xfer_ack,
  input logic          xfer_end,
  input logic          chan_en,
  input logic          done,
  input logic          cfg_err
);
  assert_end_in_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |-> xfer_ack);

  assert_ack_covers_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> xfer_ack);

  assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_we) && $stable(bus_addr)
                                && $stable(bus_size) && $stable(bus_wdata));

  assert_write_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_valid && bus_we) |-> $past(bus_valid && !bus_we && bus_ready));

  assert_final_write_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end && bus_valid && bus_we && bus_ready |=> !chan_en && done);

  assert_idle_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |-> !bus_valid);

  assert_err_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !chan_en);

  assert_done_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !chan_en);
endmodule

bind dma_norm_chan dmn_chan_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_ready (bus_ready),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_size  (bus_size),
  .bus_wdata (bus_wdata),
  .xfer_ack  (xfer_ack),
  .xfer_end  (xfer_end),
  .chan_en   (chan_en),
  .done      (done),
  .cfg_err   (cfg_err)
);

// File: tb/test_dma_norm_chan.sv
`timescale 1ns/1ps
module test_dma_norm_chan;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] cfg_src_addr = '0, cfg_dst_addr = '0, cfg_count = '0;
  logic [1:0]  cfg_size = '0;
  logic        cfg_src_inc = 1'b0, cfg_dst_inc = 1'b0, cfg_single = 1'b0, cfg_auto = 1'b0;
  logic [15:0] cfg_blk_size = '0;
  logic        ext_req = 1'b0;
  logic        bus_valid, bus_we, bus_ready, xfer_ack, xfer_end, chan_en, done, cfg_err;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [1:0]  bus_size;

  int n_cmp = 0, n_bad = 0;
  int wait_n = 0;
  int wctr = 0;

  logic [7:0]  mem [256];
  int          hs_n = 0;
  logic [31:0] hs_addr [256];
  logic        hs_we [256], hs_end [256], hs_ack [256];

  always #4 clk = ~clk;

  dma_norm_chan i_dma_norm_chan (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr), .cfg_count(cfg_count),
    .cfg_size(cfg_size), .cfg_src_inc(cfg_src_inc), .cfg_dst_inc(cfg_dst_inc),
    .cfg_single(cfg_single), .cfg_auto(cfg_auto), .cfg_blk_size(cfg_blk_size),
    .ext_req(ext_req), .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata), .xfer_ack(xfer_ack), .xfer_end(xfer_end),
    .chan_en(chan_en), .done(done), .cfg_err(cfg_err));

  function automatic logic [7:0] pat(input int a);
    return 8'(a) ^ 8'hA5;
  endfunction

  function automatic logic [31:0] rd_word(input logic [31:0] a, input logic [1:0] sz);
    logic [31:0] w;
    w = {mem[8'(a + 3)], mem[8'(a + 2)], mem[8'(a + 1)], mem[8'(a)]};
    case (sz)
      2'd0:    return {24'h0, w[7:0]};
      2'd1:    return {16'h0, w[15:0]};
      default: return w;
    endcase
  endfunction

  assign bus_ready = bus_valid && (wctr >= wait_n);
  assign bus_rdata = (bus_valid && !bus_we) ? rd_word(bus_addr, bus_size) : 32'h0;

  // Bus slave: memory, wait states and handshake log.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(i);
      wctr <= 0;
    end else begin
      if (bus_valid && !bus_ready) wctr <= wctr + 1;
      else wctr <= 0;
      if (bus_valid && bus_ready) begin
        hs_addr[8'(hs_n)] <= bus_addr;
        hs_we[8'(hs_n)]   <= bus_we;
        hs_end[8'(hs_n)]  <= xfer_end;
        hs_ack[8'(hs_n)]  <= xfer_ack;
        hs_n <= hs_n + 1;
        if (bus_we) begin
          mem[8'(bus_addr)] <= bus_wdata[7:0];
          if (bus_size >= 2'd1) mem[8'(bus_addr + 1)] <= bus_wdata[15:8];
          if (bus_size == 2'd2) begin
            mem[8'(bus_addr + 2)] <= bus_wdata[23:16];
            mem[8'(bus_addr + 3)] <= bus_wdata[31:24];
          end
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic kick(input logic [31:0] src, input logic [31:0] dst, input logic [31:0] cnt,
                      input logic [1:0] sz, input logic si, input logic di,
                      input logic single, input logic auto_m, input logic [15:0] blk);
    @(negedge clk);
    cfg_src_addr = src; cfg_dst_addr = dst; cfg_count = cnt; cfg_size = sz;
    cfg_src_inc = si; cfg_dst_inc = di; cfg_single = single; cfg_auto = auto_m;
    cfg_blk_size = blk; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (!done && t < 400) begin
      @(negedge clk);
      t++;
    end
    chk(req, {31'h0, done}, 32'h1);
  endtask

  task automatic chk_hs(input string req, input int idx, input logic [31:0] a,
                        input logic we, input logic last);
    chk(req, hs_addr[8'(idx)], a);
    chk(req, {29'h0, hs_we[8'(idx)], hs_end[8'(idx)], hs_ack[8'(idx)]}, {29'h0, we, last, 1'b1});
  endtask

  task automatic t_reset();
    chk("R1 reset outputs", {26'h0, chan_en, done, cfg_err, bus_valid, xfer_ack, xfer_end}, 32'h0);
  endtask

  task automatic t_bad_cfg();
    int b = hs_n;
    kick(32'h0, 32'h40, 32'h0, 2'd2, 1, 1, 0, 1, 16'h0);
    chk("R2 zero count error", {30'h0, cfg_err, chan_en}, 32'h2);
    kick(32'h0, 32'h40, 32'h8, 2'd3, 1, 1, 0, 1, 16'h0);
    cycles(8);
    chk("R2 size 3 error", {30'h0, cfg_err, chan_en}, 32'h2);
    chk("R2 no bus cycle", hs_n - b, 0);
  endtask

  task automatic t_dual_word();
    int b = hs_n;
    wait_n = 0;
    kick(32'h00, 32'h80, 32'd8, 2'd2, 1, 1, 0, 1, 16'h0);
    chk("R1 enabled, error cleared", {30'h0, chan_en, cfg_err}, 32'h2);
    wait_done("R9 dual word done");
    cycles(1);
    chk("R3 two word transfers", hs_n - b, 4);
    chk_hs("R4 rd0", b, 32'h00, 0, 0);
    chk_hs("R4 wr0", b + 1, 32'h80, 1, 0);
    chk_hs("R8 rd1 end", b + 2, 32'h04, 0, 1);
    chk_hs("R8 wr1 end", b + 3, 32'h84, 1, 1);
    for (int i = 0; i < 8; i++) chk("R4 word data", mem[8'(32'h80 + i)], pat(i));
    chk("R9 disabled", {31'h0, chan_en}, 0);
  endtask

  task automatic t_byte_fixed();
    int b = hs_n;
    wait_n = 2;
    kick(32'h10, 32'h90, 32'd3, 2'd0, 1, 0, 0, 1, 16'h0);
    wait_done("R10 byte run with waits");
    cycles(1);
    chk("R3 three byte transfers", hs_n - b, 6);
    chk_hs("R7 src step", b + 2, 32'h11, 0, 0);
    chk_hs("R7 dst fixed", b + 3, 32'h90, 1, 0);
    chk_hs("R8 last rd", b + 4, 32'h12, 0, 1);
    chk_hs("R7 last wr fixed", b + 5, 32'h90, 1, 1);
    chk("R7 fixed dst last byte", mem[8'h90], pat(32'h12));
    chk("R3 byte size touches one byte", mem[8'h91], pat(32'h91));
    wait_n = 0;
  endtask

  task automatic t_half_blk();
    int b = hs_n;
    int n1;
    kick(32'h20, 32'hA0, 32'd5, 2'd1, 1, 1, 0, 1, 16'h0000);
    wait_done("R3 half run");
    cycles(1);
    n1 = hs_n - b;
    chk("R3 odd count rounds up", n1, 6);
    b = hs_n;
    kick(32'h20, 32'hB0, 32'd5, 2'd1, 1, 1, 0, 1, 16'hFFFF);
    wait_done("R11 half run other block size");
    cycles(1);
    chk("R11 same cycle count", hs_n - b, n1);
    for (int i = 0; i < 6; i++) begin
      chk("R11 data A", mem[8'(32'hA0 + i)], pat(32'h20 + i));
      chk("R11 data B", mem[8'(32'hB0 + i)], pat(32'h20 + i));
    end
  endtask

  task automatic t_single();
    int b = hs_n;
    ext_req = 1'b0;
    kick(32'h30, 32'hC0, 32'd3, 2'd0, 1, 1, 1, 1, 16'h0);
    cycles(20);
    chk("R6 single waits for request", {31'h0, chan_en}, 1);
    chk("R6 no cycle without request", hs_n - b, 0);
    kick(32'h50, 32'hD0, 32'd100, 2'd2, 1, 1, 1, 1, 16'h0);
    ext_req = 1'b1;
    wait_done("R6 single done");
    cycles(10);
    chk("R1 R6 three reads only", hs_n - b, 3);
    chk_hs("R5 read 0", b, 32'h30, 0, 0);
    chk_hs("R5 read 1", b + 1, 32'h31, 0, 0);
    chk_hs("R5 read 2 end", b + 2, 32'h32, 0, 1);
    chk("R5 no write to dst", mem[8'hC0], pat(32'hC0));
    ext_req = 1'b0;
  endtask

  task automatic t_dual_ext();
    int b = hs_n;
    kick(32'h60, 32'hE0, 32'd4, 2'd2, 1, 1, 0, 0, 16'h0);
    cycles(15);
    chk("R6 dual ext waits", hs_n - b, 0);
    ext_req = 1'b1;
    wait_done("R6 dual ext done");
    ext_req = 1'b0;
    cycles(1);
    chk("R6 dual ext cycles", hs_n - b, 2);
    for (int i = 0; i < 4; i++) chk("R4 ext data", mem[8'(32'hE0 + i)], pat(32'h60 + i));
  endtask

  initial begin
    #(8 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    cycles(3);
    t_reset();
    rst_n = 1'b1;
    cycles(2);
    t_reset();
    t_bad_cfg();
    t_dual_word();
    t_byte_fixed();
    t_half_blk();
    t_single();
    t_dual_ext();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule